// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps a 16-bit record of which reset sources have fired since software last looked. The reset controller gives it a one-cycle pulse for each source it sees: external hard and soft pin resets, PLL unlock, watchdog expiry, checkstop, debugger hard and soft requests, test-port soft reset and clock-source switch. It also gets pulses from the glitch filters on the three reset pins and from the logic that guards locked configuration bits. Each pulse sets a flag. The flag stays set until software clears it by writing a one over a plain register bus made of a select strobe, a write strobe, write data and read data.

Only power-on reset clears the register, so it keeps its contents through every hard and soft reset that it records. An internal cause sets its own flag and also sets both the external-hard and external-soft flags. When software sees both external flags set together, it knows the cause was internal. A soft reset from any source drives the soft pin, so it also sets the soft-pin glitch flag.

Top module: `rst_cause_status`

## Requirements
- R1: While `por_n` is low, `reg_rdata` reads 0x0000 at once, whatever the other inputs do. This input is the only reset of the register.
- R2: A pulse on one source input sets its flag at the next rising clock edge, and `reg_rdata` shows it from then on. The flag positions are: external hard 0x8000, external soft 0x4000, PLL unlock 0x2000, watchdog 0x1000, checkstop 0x0800, debug hard 0x0400, debug soft 0x0200, test-port soft 0x0100, clock switch 0x0080, lock violation 0x0040, power-on pin glitch 0x0020, hard pin glitch 0x0010, soft pin glitch 0x0008.
- R3: Each internal source also sets 0x8000 and 0x4000 in the same edge. The internal sources are PLL unlock, watchdog, checkstop, debug hard, debug soft, test-port soft and clock switch.
- R4: A soft reset also sets the soft pin glitch flag 0x0008 in the same edge. The soft resets are external soft, debug soft and test-port soft.
- R5: A set flag stays set on every later edge until it is cleared by a write or by R1.
- R6: A write is `reg_sel` and `reg_wr` both high at a rising edge. It clears each flag whose bit in `reg_wdata` is one. Bits written as zero are left as they were.
- R7: A write strobe without `reg_sel` changes nothing. Bits 0x0007 always read zero and do not respond to writes.
- R8: When a set and a clear hit the same flag at the same edge, the flag ends up set.
- R9: Pulses that arrive together on several inputs all take effect at the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ev_ext_hard | input | 1 | External hard reset seen |
| ev_ext_soft | input | 1 | External soft reset seen |
| ev_pll_unlock | input | 1 | Enabled PLL unlock reset |
| ev_watchdog | input | 1 | Watchdog expiry reset |
| ev_checkstop | input | 1 | Enabled checkstop reset |
| ev_dbg_hard | input | 1 | Debugger hard reset request |
| ev_dbg_soft | input | 1 | Debugger soft reset request |
| ev_tap_soft | input | 1 | Test-port soft reset |
| ev_clk_switch | input | 1 | Clock source switch reset |
| ev_lock_violation | input | 1 | Locked configuration bit changed |
| gl_por_pin | input | 1 | Glitch on power-on pin |
| gl_hard_pin | input | 1 | Glitch on hard reset pin |
| gl_soft_pin | input | 1 | Glitch on soft reset pin |
| reg_sel | input | 1 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data, where a one clears a flag |
| reg_rdata | output | 16 | Current flags, readable at any time |

## Verification
The assertions assume that every event input is synchronous to `clk`. They also assume that `por_n` is low from time zero until after the first edge, so that no property looks back at a value from before reset. The stimulus changes every input only on the falling edge and holds power-on reset low from the start. Strobes and data are always driven with known values. Pulses are one cycle wide, apart from the cycles where several sources are raised together on purpose.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;

  localparam int NUM_FLAGS = 13;

  typedef enum int {
    FL_EXT_HARD   = 0,
    FL_EXT_SOFT   = 1,
    FL_PLL_UNLOCK = 2,
    FL_WATCHDOG   = 3,
    FL_CHECKSTOP  = 4,
    FL_DBG_HARD   = 5,
    FL_DBG_SOFT   = 6,
    FL_TAP_SOFT   = 7,
    FL_CLK_SWITCH = 8,
    FL_LOCK_VIOL  = 9,
    FL_GL_POR     = 10,
    FL_GL_HARD    = 11,
    FL_GL_SOFT    = 12
  } flag_e;

  // flag index k -> bit k of these masks
  localparam logic [NUM_FLAGS-1:0] INTERNAL_MASK = 13'h01FC;
  localparam logic [NUM_FLAGS-1:0] SOFT_MASK     = 13'h00C2;

  // flag 0 sits at the most significant data bit
  function automatic int flag_pos(input int reg_w, input int k);
    return reg_w - 1 - k;
  endfunction

endpackage

// File: rtl/rst_cause_setmap.sv
module rst_cause_setmap
  import rst_cause_pkg::*;
(
  input  logic [NUM_FLAGS-1:0] ev,
  output logic [NUM_FLAGS-1:0] set_vec
);

  logic any_internal;
  logic any_soft;

  assign any_internal = |(ev & INTERNAL_MASK);
  assign any_soft     = |(ev & SOFT_MASK);

  always_comb begin
    set_vec = ev;
    set_vec[FL_EXT_HARD] = ev[FL_EXT_HARD] | any_internal;
    set_vec[FL_EXT_SOFT] = ev[FL_EXT_SOFT] | any_internal;
    set_vec[FL_GL_SOFT]  = ev[FL_GL_SOFT]  | any_soft;
  end

endmodule

// File: rtl/rst_cause_bit.sv
module rst_cause_bit (
  input  logic clk,
  input  logic por_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)     q <= 1'b0;
    else if (set_i) q <= 1'b1;   // set outranks clear
    else if (clr_i) q <= 1'b0;
  end

endmodule

// File: rtl/rst_cause_status.sv
module rst_cause_status
  import rst_cause_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             ev_ext_hard,
  input  logic             ev_ext_soft,
  input  logic             ev_pll_unlock,
  input  logic             ev_watchdog,
  input  logic             ev_checkstop,
  input  logic             ev_dbg_hard,
  input  logic             ev_dbg_soft,
  input  logic             ev_tap_soft,
  input  logic             ev_clk_switch,
  input  logic             ev_lock_violation,
  input  logic             gl_por_pin,
  input  logic             gl_hard_pin,
  input  logic             gl_soft_pin,
  input  logic             reg_sel,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata
);

  localparam int RSVD_W = REG_W - NUM_FLAGS;

  logic [NUM_FLAGS-1:0] ev_vec;
  logic [NUM_FLAGS-1:0] set_vec;
  logic [NUM_FLAGS-1:0] flag_q;
  logic                 wr_hit;

  always_comb begin
    ev_vec                = '0;
    ev_vec[FL_EXT_HARD]   = ev_ext_hard;
    ev_vec[FL_EXT_SOFT]   = ev_ext_soft;
    ev_vec[FL_PLL_UNLOCK] = ev_pll_unlock;
    ev_vec[FL_WATCHDOG]   = ev_watchdog;
    ev_vec[FL_CHECKSTOP]  = ev_checkstop;
    ev_vec[FL_DBG_HARD]   = ev_dbg_hard;
    ev_vec[FL_DBG_SOFT]   = ev_dbg_soft;
    ev_vec[FL_TAP_SOFT]   = ev_tap_soft;
    ev_vec[FL_CLK_SWITCH] = ev_clk_switch;
    ev_vec[FL_LOCK_VIOL]  = ev_lock_violation;
    ev_vec[FL_GL_POR]     = gl_por_pin;
    ev_vec[FL_GL_HARD]    = gl_hard_pin;
    ev_vec[FL_GL_SOFT]    = gl_soft_pin;
  end

  assign wr_hit = reg_sel & reg_wr;

  rst_cause_setmap u_map (
    .ev      (ev_vec),
    .set_vec (set_vec)
  );

  for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_flag
    rst_cause_bit u_bit (
      .clk   (clk),
      .por_n (por_n),
      .set_i (set_vec[k]),
      .clr_i (wr_hit & reg_wdata[flag_pos(REG_W, k)]),
      .q     (flag_q[k])
    );
    assign reg_rdata[flag_pos(REG_W, k)] = flag_q[k];
  end

  if (RSVD_W > 0) begin : g_rsvd
    assign reg_rdata[RSVD_W-1:0] = '0;
  end

endmodule

// File: rtl/rst_cause_chk.sv
module rst_cause_chk #(
  parameter int REG_W = 16
) (
  input logic             clk,
  input logic             por_n,
  input logic             ev_ext_hard,
  input logic             ev_ext_soft,
  input logic             ev_pll_unlock,
  input logic             ev_watchdog,
  input logic             ev_checkstop,
  input logic             ev_dbg_hard,
  input logic             ev_dbg_soft,
  input logic             ev_tap_soft,
  input logic             ev_clk_switch,
  input logic             ev_lock_violation,
  input logic             gl_por_pin,
  input logic             gl_hard_pin,
  input logic             gl_soft_pin,
  input logic             reg_sel,
  input logic             reg_wr,
  input logic [REG_W-1:0] reg_wdata,
  input logic [REG_W-1:0] reg_rdata
);

  logic any_ev;
  assign any_ev = ev_ext_hard | ev_ext_soft | ev_pll_unlock | ev_watchdog |
                  ev_checkstop | ev_dbg_hard | ev_dbg_soft | ev_tap_soft |
                  ev_clk_switch | ev_lock_violation | gl_por_pin |
                  gl_hard_pin | gl_soft_pin;

  AST_NO_SPONTANEOUS_SET: assert property (@(posedge clk) disable iff (!por_n)
    !any_ev |=> ((reg_rdata & ~$past(reg_rdata)) == '0)); // R2

  AST_INTERNAL_SETS_BOTH: assert property (@(posedge clk) disable iff (!por_n)
    ev_watchdog |=> (reg_rdata[REG_W-1] && reg_rdata[REG_W-2])); // R3

  AST_SOFT_SETS_PIN_FLAG: assert property (@(posedge clk) disable iff (!por_n)
    ev_tap_soft |=> reg_rdata[REG_W-13]); // R4

  AST_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    !(reg_sel && reg_wr) |=> ((~reg_rdata & $past(reg_rdata)) == '0)); // R5

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
    (reg_sel && reg_wr && !any_ev) |=> ((reg_rdata & $past(reg_wdata)) == '0)); // R6

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!por_n)
    (ev_ext_hard && reg_sel && reg_wr) |=> reg_rdata[REG_W-1]); // R8

endmodule

bind rst_cause_status rst_cause_chk #(.REG_W(REG_W)) u_chk (
  .clk(clk), .por_n(por_n),
  .ev_ext_hard(ev_ext_hard), .ev_ext_soft(ev_ext_soft),
  .ev_pll_unlock(ev_pll_unlock), .ev_watchdog(ev_watchdog),
  .ev_checkstop(ev_checkstop), .ev_dbg_hard(ev_dbg_hard),
  .ev_dbg_soft(ev_dbg_soft), .ev_tap_soft(ev_tap_soft),
  .ev_clk_switch(ev_clk_switch), .ev_lock_violation(ev_lock_violation),
  .gl_por_pin(gl_por_pin), .gl_hard_pin(gl_hard_pin), .gl_soft_pin(gl_soft_pin),
  .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
);

// File: tb/sim_rst_cause_status.sv
module sim_rst_cause_status;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic [12:0] ev = '0;   // bench order: index k is flag k of R2
  logic        reg_sel = 1'b0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [15:0] model = '0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;  // 250 MHz

  rst_cause_status u0 (
    .clk(clk), .por_n(por_n),
    .ev_ext_hard(ev[0]), .ev_ext_soft(ev[1]), .ev_pll_unlock(ev[2]),
    .ev_watchdog(ev[3]), .ev_checkstop(ev[4]), .ev_dbg_hard(ev[5]),
    .ev_dbg_soft(ev[6]), .ev_tap_soft(ev[7]), .ev_clk_switch(ev[8]),
    .ev_lock_violation(ev[9]), .gl_por_pin(ev[10]), .gl_hard_pin(ev[11]),
    .gl_soft_pin(ev[12]),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  function automatic logic [15:0] set_mask(input logic [12:0] e);
    logic [15:0] m = '0;
    for (int k = 0; k < 13; k++) begin
      if (e[k]) begin
        m[15-k] = 1'b1;                                  // R2
        if (k >= 2 && k <= 8) m = m | 16'hC000;          // R3
        if (k == 1 || k == 6 || k == 7) m = m | 16'h0008; // R4
      end
    end
    return m;
  endfunction

  // driver: applies one cycle of stimulus and queues the expected result
  task automatic step(input logic por, input logic [12:0] e, input logic sel,
                      input logic wr, input logic [15:0] wd, input string tag);
    @(negedge clk);
    por_n = por; ev = e; reg_sel = sel; reg_wr = wr; reg_wdata = wd;
    if (!por) model = '0;
    else begin
      if (sel && wr) model = model & ~wd;
      model = (model | set_mask(e)) & 16'hFFF8;
    end
    exp_q.push_back(model);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input string tag);
    step(1'b1, '0, 1'b0, 1'b0, '0, tag);
  endtask

  // monitor: compares just after each rising edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (reg_rdata !== e) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", t, reg_rdata, e);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(1'b0, '0, 1'b0, 1'b0, '0, "R1 reset state");
    step(1'b0, 13'h1FFF, 1'b0, 1'b0, '0, "R1 events held off by reset");
    idle("R1 after release");

    // every source alone, then clear all
    for (int k = 0; k < 13; k++) begin
      step(1'b1, 13'(1 << k), 1'b0, 1'b0, '0, "R2 R3 R4 single source");
      step(1'b1, '0, 1'b1, 1'b1, 16'hFFFF, "R6 clear all");
    end

    // sticky and ignored writes
    step(1'b1, 13'(1 << 3), 1'b0, 1'b0, '0, "R3 watchdog");
    idle("R5 sticky 1");
    idle("R5 sticky 2");
    step(1'b1, '0, 1'b0, 1'b1, 16'hFFFF, "R7 write without select");
    step(1'b1, '0, 1'b1, 1'b1, 16'h0000, "R6 zero write no effect");
    step(1'b1, '0, 1'b1, 1'b1, 16'h0007, "R7 reserved write");
    step(1'b1, '0, 1'b1, 1'b1, 16'h1000, "R6 clear watchdog only");
    step(1'b1, '0, 1'b1, 1'b1, 16'hC008, "R6 clear remaining");

    // set beats clear
    step(1'b1, 13'(1 << 0), 1'b0, 1'b0, '0, "R2 ext hard");
    step(1'b1, 13'(1 << 0), 1'b1, 1'b1, 16'h8000, "R8 set with clear");
    idle("R8 still set");

    // simultaneous events
    step(1'b1, 13'h0C10, 1'b0, 1'b0, '0, "R9 three at once");
    step(1'b1, 13'h0281, 1'b1, 1'b1, 16'h0800, "R9 mixed with clear");
    idle("R5 hold");

    // power-on reset in mid-run
    step(1'b0, '0, 1'b0, 1'b0, '0, "R1 mid-run reset");
    idle("R1 stays clear");

    @(negedge clk); @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule